// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block forms the byte address for a single 32-bit word load or store, and the value the base register should take afterwards. A request carries a base value, an offset source and three control fields. The offset source is either an unsigned 12-bit immediate or a register value scaled by a left shift of 0 to 3 places. The control fields are the indexing mode, the offset direction and a write-back request. The block adds or subtracts the offset and chooses among three modes. The effective address can be the base itself, or the offset sum before the access (pre-indexing). In the third mode the base is used for the access and the sum becomes the new base (post-indexing).

Requests arrive on a valid/ready input channel. Results leave on a valid/ready output channel through a single register stage. The input is ready whenever the output stage is empty, or whenever its content is being taken in the same cycle. While the output is held by back-pressure, every output field stays frozen. The base-update strobe is asserted in the single cycle in which a result is handed over, and only when that result calls for a base register write. A misalign flag travels with each result.

Top module: `idx_addr_gen`

## Requirements
- R1: With `in_mode` = 0 (base only) or 3 (reserved, treated the same), the effective address and the new base both equal the base, and the strobe is never asserted.
- R2: With `in_mode` = 1 (pre-indexed), the effective address is the base plus the offset when `in_up` = 1, or minus the offset when `in_up` = 0.
- R3: In pre-indexed mode with `in_wb` = 1, the new base equals the effective address and the strobe is raised. With `in_wb` = 0, the new base equals the base and the strobe stays low.
- R4: With `in_mode` = 2 (post-indexed), the effective address is the unmodified base. The new base is the base plus or minus the offset, and the strobe is raised whatever `in_wb` holds.
- R5: With `in_use_reg` = 1, the offset is `in_offreg` shifted left logically by `in_shamt` places. For example, 3 with a shift of 2 gives 12.
- R6: With `in_use_reg` = 0, the offset is `in_imm` zero-extended. The offset direction comes only from `in_up`.
- R7: `out_misalign` is 1 exactly when bit 1 or bit 0 of `out_addr` is 1.
- R8: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` = 1 and `out_ready` = 0, every output field holds its value into the next cycle.
- R9: `out_base_wr` is asserted only in a cycle in which `out_valid` and `out_ready` are both 1, so it pulses once for each result that calls for a base write.
- R10: After reset, `out_valid` and `out_base_wr` are 0.
- R11: Address arithmetic wraps modulo 2^32. For example, 0xFFFFFFF8 + 16 gives 0x00000008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_base | input | 32 | Base register value |
| in_offreg | input | 32 | Offset register value |
| in_imm | input | 12 | Unsigned immediate offset |
| in_shamt | input | 2 | Left shift amount for the register offset |
| in_use_reg | input | 1 | 1: register offset, 0: immediate |
| in_mode | input | 2 | 0 base only, 1 pre-indexed, 2 post-indexed, 3 as 0 |
| in_up | input | 1 | 1: add offset, 0: subtract offset |
| in_wb | input | 1 | Write-back request (pre-indexed mode only) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_addr | output | 32 | Effective byte address |
| out_new_base | output | 32 | Base register value after the access |
| out_base_wr | output | 1 | Base update strobe, one cycle per handover |
| out_misalign | output | 1 | Effective address not word aligned |

## Verification
The case that is hardest to reach is a result held under back-pressure while new requests keep arriving. There the bench has to show three things: the held fields stay frozen, no request is lost or duplicated, and the strobe fires once, at the handover, rather than once per stalled cycle. To get there, the bench runs with `out_ready` driven from a pseudo-random bit pattern and with requests issued back to back. A strobe-carrying post-indexed result is then often stalled for several cycles with the next request waiting at the input. A scoreboard queue keeps the expected results in order through those stalls.

// File: rtl/idx_agu_pkg.sv
package idx_agu_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned IMM_W   = 12;
  localparam int unsigned SHAMT_W = 2;
  localparam int unsigned WORD_LSB = 2;

  typedef enum logic [1:0] {
    IDX_NONE = 2'd0,
    IDX_PRE  = 2'd1,
    IDX_POST = 2'd2,
    IDX_RSVD = 2'd3
  } idx_mode_e;
endpackage

// File: rtl/idx_offset_unit.sv
module idx_offset_unit #(
  parameter int unsigned AW   = 32,
  parameter int unsigned IMMW = 12,
  parameter int unsigned SHW  = 2
) (
  input  logic            use_reg,
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0]   offreg,
  input  logic [SHW-1:0]  shamt,
  output logic [AW-1:0]   offset
);
  localparam int unsigned PADW = AW - IMMW;

  logic [AW-1:0] scaled;
  logic [AW-1:0] imm_ext;

  always_comb begin
    scaled  = offreg << shamt;
    imm_ext = {{PADW{1'b0}}, imm};
    offset  = use_reg ? scaled : imm_ext;
  end
endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
  import idx_agu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic          up,
  input  idx_mode_e     mode,
  input  logic          wb,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] new_base,
  output logic          base_wr
);
  logic [AW-1:0] sum;

  always_comb begin
    sum = up ? (base + offset) : (base - offset);
    eff_addr = base;
    new_base = base;
    base_wr  = 1'b0;
    unique case (mode)
      IDX_PRE: begin
        eff_addr = sum;
        if (wb) begin
          new_base = sum;
          base_wr  = 1'b1;
        end
      end
      IDX_POST: begin
        new_base = sum;
        base_wr  = 1'b1;
      end
      default: begin
        eff_addr = base;
      end
    endcase
  end
endmodule

// File: rtl/idx_align_check.sv
module idx_align_check #(
  parameter int unsigned AW   = 32,
  parameter int unsigned LSBS = 2
) (
  input  logic [AW-1:0] addr,
  output logic          misalign
);
  generate
    if (LSBS == 0) begin : g_none
      assign misalign = 1'b0;
    end else begin : g_chk
      assign misalign = |addr[LSBS-1:0];
    end
  endgenerate
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idx_agu_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned IMMW = IMM_W,
  parameter int unsigned SHW  = SHAMT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [AW-1:0]   in_base,
  input  logic [AW-1:0]   in_offreg,
  input  logic [IMMW-1:0] in_imm,
  input  logic [SHW-1:0]  in_shamt,
  input  logic            in_use_reg,
  input  logic [1:0]      in_mode,
  input  logic            in_up,
  input  logic            in_wb,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_addr,
  output logic [AW-1:0]   out_new_base,
  output logic            out_base_wr,
  output logic            out_misalign
);
  logic [AW-1:0] offset;
  logic [AW-1:0] ea_c;
  logic [AW-1:0] nb_c;
  logic          wr_c;
  logic          mis_c;
  logic          wr_q;
  idx_mode_e     mode_c;
  idx_mode_e     mode_q;
  logic          wb_q;
  logic          take;

  assign mode_c = idx_mode_e'(in_mode);

  idx_offset_unit #(.AW(AW), .IMMW(IMMW), .SHW(SHW)) u_off (
    .use_reg (in_use_reg),
    .imm     (in_imm),
    .offreg  (in_offreg),
    .shamt   (in_shamt),
    .offset  (offset)
  );

  idx_addr_calc #(.AW(AW)) u_calc (
    .base     (in_base),
    .offset   (offset),
    .up       (in_up),
    .mode     (mode_c),
    .wb       (in_wb),
    .eff_addr (ea_c),
    .new_base (nb_c),
    .base_wr  (wr_c)
  );

  idx_align_check #(.AW(AW), .LSBS(WORD_LSB)) u_align (
    .addr     (ea_c),
    .misalign (mis_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_new_base <= '0;
      out_misalign <= 1'b0;
      wr_q         <= 1'b0;
      wb_q         <= 1'b0;
      mode_q       <= IDX_NONE;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_addr     <= ea_c;
        out_new_base <= nb_c;
        out_misalign <= mis_c;
        wr_q         <= wr_c;
        wb_q         <= in_wb;
        mode_q       <= mode_c;
      end
    end
  end

  assign out_base_wr = out_valid && out_ready && wr_q;

  p_reset_r10: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_base_wr);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_new_base)
                                && $stable(out_misalign));

  p_strobe_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_base_wr |-> out_valid && out_ready);

  p_base_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (mode_q == IDX_NONE || mode_q == IDX_RSVD) |->
      !out_base_wr && out_new_base == out_addr);

  p_pre_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == IDX_PRE && wb_q |-> out_new_base == out_addr);

  p_post_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == IDX_POST |-> out_base_wr == out_ready);
endmodule

// File: tb/idx_addr_gen_bench.sv
module idx_addr_gen_bench;
  typedef struct {
    logic [31:0] addr;
    logic [31:0] nb;
    logic        wr;
    logic        mis;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_base = '0;
  logic [31:0] in_offreg = '0;
  logic [11:0] in_imm = '0;
  logic [1:0]  in_shamt = '0;
  logic        in_use_reg = 1'b0;
  logic [1:0]  in_mode = '0;
  logic        in_up = 1'b0;
  logic        in_wb = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [31:0] out_new_base;
  logic        out_base_wr;
  logic        out_misalign;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit rand_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  exp_t sb[$];

  always #5 clk = ~clk;

  idx_addr_gen u_idx_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_offreg(in_offreg), .in_imm(in_imm), .in_shamt(in_shamt),
    .in_use_reg(in_use_reg), .in_mode(in_mode), .in_up(in_up), .in_wb(in_wb),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_new_base(out_new_base), .out_base_wr(out_base_wr), .out_misalign(out_misalign)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // back-pressure pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= rand_ready ? lfsr[3] : 1'b1;
  end

  task automatic send(input logic [31:0] base, input logic [31:0] oreg, input logic [11:0] imm,
                      input logic [1:0] sh, input logic ureg, input logic [1:0] mode,
                      input logic up, input logic wb, input string tag);
    exp_t e;
    logic [31:0] off;
    logic [31:0] sum;
    off = ureg ? (oreg << sh) : {20'd0, imm};
    sum = up ? base + off : base - off;
    case (mode)
      2'd1: begin e.addr = sum; e.nb = wb ? sum : base; e.wr = wb; end
      2'd2: begin e.addr = base; e.nb = sum; e.wr = 1'b1; end
      default: begin e.addr = base; e.nb = base; e.wr = 1'b0; end
    endcase
    e.mis = |e.addr[1:0];
    e.tag = tag;
    @(negedge clk);
    in_valid = 1'b1; in_base = base; in_offreg = oreg; in_imm = imm; in_shamt = sh;
    in_use_reg = ureg; in_mode = mode; in_up = up; in_wb = wb;
    while (!in_ready) @(negedge clk);
    sb.push_back(e);
    @(posedge clk);
    #2 in_valid = 1'b0;
  endtask

  // monitor: compare at negedge when the handover will happen on the next edge
  logic        held = 1'b0;
  logic [31:0] held_addr, held_nb;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held && out_valid) begin
        chk("R8 hold addr", out_addr, held_addr);
        chk("R8 hold new_base", out_new_base, held_nb);
      end
      held = 1'b0;
      if (out_valid && !out_ready) begin
        held = 1'b1; held_addr = out_addr; held_nb = out_new_base;
        chk("R9 no strobe while stalled", {31'd0, out_base_wr}, 32'd0);
        chk("R8 in_ready low while stalled", {31'd0, in_ready}, 32'd0);
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          chk("R9 unexpected result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " addr"}, out_addr, e.addr);
          chk({e.tag, " new_base"}, out_new_base, e.nb);
          chk({e.tag, " R9 strobe"}, {31'd0, out_base_wr}, {31'd0, e.wr});
          chk({e.tag, " R7 misalign"}, {31'd0, out_misalign}, {31'd0, e.mis});
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10 reset strobe", {31'd0, out_base_wr}, 32'd0);
    rst_n = 1'b1;
    // directed cases
    send(32'h200, 0, 12'd12, 0, 0, 2'd1, 1, 0, "R2 R6 pre +12");
    send(32'h200, 0, 12'd12, 0, 0, 2'd1, 0, 1, "R3 pre -12 wb");
    send(32'h200, 0, 12'd12, 0, 0, 2'd1, 1, 0, "R3 pre no wb");
    send(32'h200, 32'd3, 12'd0, 2'd2, 1, 2'd2, 1, 0, "R4 R5 post reg 3<<2");
    send(32'h200, 0, 12'd12, 0, 0, 2'd2, 0, 1, "R4 post -12");
    send(32'h1234, 0, 12'hFFF, 0, 0, 2'd0, 1, 1, "R1 base mode");
    send(32'h1237, 32'h55, 12'h10, 1, 1, 2'd3, 0, 1, "R1 reserved mode");
    send(32'h200, 0, 12'd13, 0, 0, 2'd1, 1, 0, "R7 misaligned pre");
    send(32'hFFFF_FFF8, 0, 12'd16, 0, 0, 2'd1, 1, 1, "R11 wrap up");
    send(32'h0000_0004, 0, 12'd8, 0, 0, 2'd2, 0, 0, "R11 wrap down");
    send(32'h1000, 0, 12'hFFF, 0, 0, 2'd1, 0, 0, "R6 imm max subtract");
    for (int s = 0; s < 4; s++)
      send(32'h400, 32'h8000_0001, 12'hABC, s[1:0], 1, 2'd1, 1, 1, "R5 shift sweep");
    // back-pressure phase
    rand_ready = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      send($urandom, $urandom, r[11:0], r[13:12], r[14], r[16:15], r[17], r[18],
           "R8 R9 random");
    end
    rand_ready = 1'b0;
    repeat (5) @(posedge clk);
    chk("R9 scoreboard drained", sb.size(), 0);
    summary();
  end
endmodule